// File: doc/BRIEF.md
# Address-Sequence Store/Recall Detector

This block snoops the access bus of a memory with a 13-bit address and spots a software command hidden in ordinary reads. The command is six enabled read accesses in a row. The first five addresses form a fixed prefix. The sixth address picks the action: a nonvolatile save, a nonvolatile restore, or a reserved test pattern that must do nothing.

When a save or restore sequence completes, the block raises a single-cycle request toward the nonvolatile controller. During that sixth access it also tells the memory's data drivers to float. The memory array and the nonvolatile transfer itself sit outside this block.

Accesses are counted only when chip select is active and the per-access strobe is high. Idle bus cycles neither advance nor break a partly matched sequence.

Top module: `addr_knock_detect`

## Requirements
- R1: After reset, `save_req`, `restore_req` and `drv_float` are low, and no partial sequence is held.
- R2: Enabled reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F make `save_req` high for exactly the one cycle after the clock edge that ends the sixth access.
- R3: The same five-address prefix followed by 0x0F0E makes `restore_req` high for exactly one cycle, with the same timing as R2.
- R4: The prefix followed by 0x139C raises neither request, and it does not drive `drv_float`.
- R5: An enabled access with `wr_n` low resets the tracker, even at address 0x0000. The sequence must then begin again from its first address.
- R6: `rd_en_n` has no effect on recognition or on any output.
- R7: `drv_float` is high, combinationally, only during the sixth enabled read of a save or restore sequence. It is low during the five prefix reads and at all other times.
- R8: A cycle with `cs_n` high or `acc_stb` low is not counted, and it leaves a partial sequence intact.
- R9: An enabled read whose address does not match the next expected address drops the partial sequence. If that address is 0x0000, it counts as the first step of a new sequence.
- R10: `save_req` and `restore_req` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Output enable, active low (ignored) |
| acc_stb | input | 1 | High for one cycle per bus access |
| addr | input | 13 | Access address |
| save_req | output | 1 | One-cycle nonvolatile save request |
| restore_req | output | 1 | One-cycle nonvolatile restore request |
| drv_float | output | 1 | Data drivers must be high impedance |

## Verification
The assertions assume that the bus inputs are settled before each rising edge and that one access lasts exactly one strobed cycle. The bench drives every input on the falling edge, so those values hold steady through the next rising edge. Its random addresses are biased toward the next expected prefix address so that full sequences actually occur. It also mixes in idle cycles, writes, the reserved final address and stray 0x0000 addresses, and it toggles output enable freely. None of this steps outside the assumed single-cycle access protocol.

// File: rtl/addr_knock_detect.sv
module addr_knock_detect #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] PFX0 = 13'h0000,
  parameter logic [ADDR_W-1:0] PFX1 = 13'h1555,
  parameter logic [ADDR_W-1:0] PFX2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] PFX3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] PFX4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] FIN_SAVE = 13'h0F0F,
  parameter logic [ADDR_W-1:0] FIN_RESTORE = 13'h0F0E,
  parameter logic [ADDR_W-1:0] FIN_TEST = 13'h139C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic              save_req,
  output logic              restore_req,
  output logic              drv_float
);
  localparam int PFX_LEN = 5;
  localparam int STEP_W = $clog2(PFX_LEN + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PFX_LEN);

  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] want;
  logic unused_oe;

  assign unused_oe = rd_en_n;

  wire acc      = !cs_n && acc_stb;
  wire rd       = acc && wr_n;
  wire at_final = (step == LAST);
  wire hit_pfx  = rd && !at_final && (addr == want);
  wire hit_save = rd && at_final && (addr == FIN_SAVE);
  wire hit_rest = rd && at_final && (addr == FIN_RESTORE);
  wire hit_test = rd && at_final && (addr == FIN_TEST);

  always_comb begin
    case (step)
      STEP_W'(0): want = PFX0;
      STEP_W'(1): want = PFX1;
      STEP_W'(2): want = PFX2;
      STEP_W'(3): want = PFX3;
      default:    want = PFX4;
    endcase
  end

  assign drv_float = hit_save || hit_rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step        <= '0;
      save_req    <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      save_req    <= hit_save;
      restore_req <= hit_rest;
      if (acc) begin
        if (!wr_n)               step <= '0;
        else if (hit_pfx)        step <= step + 1'b1;
        else if (addr == PFX0)   step <= STEP_W'(1);
        else                     step <= '0;
      end
    end
  end

  AST_REQ_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(save_req && restore_req)); // R10
  AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) save_req |=> !save_req); // R10
  AST_REST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) restore_req |=> !restore_req); // R10
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !acc |=> $stable(step)); // R8
  AST_WR_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (acc && !wr_n) |=> step == '0); // R5
  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hit_test |=> !save_req && !restore_req); // R4
  AST_FLOAT_REQ:  assert property (@(posedge clk) disable iff (!rst_n) drv_float |=> (save_req || restore_req)); // R7
  AST_REQ_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) (save_req || restore_req) |-> $past(at_final && rd)); // R2
endmodule

// File: tb/addr_knock_detect_tb.sv
module addr_knock_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_en_n = 1'b1, acc_stb = 1'b0;
  logic [12:0] addr = '0;
  logic save_req, restore_req, drv_float;

  int checks = 0;
  int errors = 0;
  int m_step = 0;
  logic e_save = 1'b0, e_rest = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_knock_detect u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_en_n(rd_en_n),
    .acc_stb(acc_stb), .addr(addr), .save_req(save_req),
    .restore_req(restore_req), .drv_float(drv_float)
  );

  function automatic logic [12:0] pfx(int i);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  function automatic bit exp_float(int st, logic c, logic w, logic s, logic [12:0] a);
    return !c && s && w && st == 5 && (a == 13'h0F0F || a == 13'h0F0E);
  endfunction

  function automatic int next_step(int st, logic c, logic w, logic s, logic [12:0] a);
    if (c || !s) return st;
    if (!w) return 0;
    if (st < 5 && a == pfx(st)) return st + 1;
    if (a == 13'h0000) return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic w, logic s, logic o, logic [12:0] a, string req);
    @(negedge clk);
    cs_n = c; wr_n = w; acc_stb = s; rd_en_n = o; addr = a;
    #1;
    chk(req, drv_float, exp_float(m_step, c, w, s, a), "drv_float");
    e_save = !c && s && w && m_step == 5 && a == 13'h0F0F;
    e_rest = !c && s && w && m_step == 5 && a == 13'h0F0E;
    m_step = next_step(m_step, c, w, s, a);
    @(posedge clk);
    #1;
    chk(req, save_req, e_save, "save_req");
    chk(req, restore_req, e_rest, "restore_req");
  endtask

  task automatic rd(logic [12:0] a, string req);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, a, req);
  endtask

  task automatic prefix(string req);
    for (int i = 0; i < 5; i++) rd(pfx(i), req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #10;
    chk("R1", save_req, 1'b0, "reset save_req");
    chk("R1", restore_req, 1'b0, "reset restore_req");
    chk("R1", drv_float, 1'b0, "reset drv_float");
    @(negedge clk); rst_n = 1'b1;

    prefix("R2"); rd(13'h0F0F, "R2");
    rd(13'h1234, "R10");
    prefix("R3"); rd(13'h0F0E, "R3");
    prefix("R4"); rd(13'h139C, "R4");
    prefix("R5"); rd(13'h0F0F, "R5");

    rd(13'h0000, "R5"); rd(13'h1555, "R5");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 13'h0AAA, "R5");
    rd(13'h1FFF, "R5"); rd(13'h10F0, "R5"); rd(13'h0F0F, "R5");

    rd(13'h0000, "R5"); cyc(1'b0, 1'b0, 1'b1, 1'b0, 13'h0000, "R5");
    rd(13'h1555, "R5");

    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, pfx(i), "R6");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 13'h0F0E, "R6");

    rd(13'h0000, "R8"); rd(13'h1555, "R8");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 13'h0123, "R8");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 13'h0444, "R8");
    rd(13'h0AAA, "R8"); rd(13'h1FFF, "R8"); rd(13'h10F0, "R8"); rd(13'h0F0F, "R8");

    rd(13'h0000, "R9"); rd(13'h1555, "R9"); rd(13'h0000, "R9");
    rd(13'h1555, "R9"); rd(13'h0AAA, "R9"); rd(13'h1FFF, "R9");
    rd(13'h10F0, "R9"); rd(13'h0F0E, "R9");

    for (int n = 0; n < 4000; n++) begin
      logic c, w, s, o;
      logic [12:0] a;
      int r;
      string tag;
      r = $urandom_range(99);
      c = (r < 8);
      s = ($urandom_range(99) >= 8);
      w = ($urandom_range(99) >= 4);
      o = 1'($urandom);
      r = $urandom_range(99);
      if (r < 65) a = (m_step < 5) ? pfx(m_step) : 13'h0F0F;
      else if (r < 75) a = 13'h0F0E;
      else if (r < 82) a = 13'h139C;
      else if (r < 90) a = 13'h0000;
      else a = 13'($urandom);
      tag = (m_step == 5) ? (a == 13'h0F0F ? "R2" : a == 13'h0F0E ? "R3" : "R4") : "R9";
      cyc(c, w, s, o, a, tag);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule